// File: doc/BRIEF.md
# Fractional-N Divide Controller with First-Order Accumulator

This block sets the feedback division ratio of a fractional-N frequency synthesizer. It contains a reloadable down-counter that divides a stream of input strobes, plus an m-bit phase accumulator that steps once at the end of every division cycle. The accumulator adds a fractional word k to its residue. Its carry chooses whether the next division cycle lasts N+1 strobes or N strobes. Over time the average ratio settles at N + k/2^m, so the synthesized frequency is (N + k/2^m) times the comparison frequency.

The clock is the fast domain in which the block runs. The `cyc_stb` input marks each prescaled edge that is to be counted, and it acts as a clock enable for the whole block. The `div_out` output pulses once for every completed division cycle and is the signal fed to the phase detector. The block samples the integer word and the fractional word only at the end of a cycle, so they can be changed at any time without creating a partial cycle. The integer word must be at least 1.

Top module: `fracn_divctl`

## Requirements
- R1: While `rst_n` is low and until the first strobe afterwards, `acc_res` is 0, `acc_carry` is 0, `div_out` is 0 and `div_ratio` is 1, so the first division cycle after reset is one strobe long.
- R2: The counter advances only on clock edges where `cyc_stb` is high. Each division cycle ends on the strobe that completes `div_ratio` strobes, and `div_out` is high for exactly the one clock cycle after that edge. A low strobe leaves `acc_res`, `acc_carry` and `div_ratio` unchanged.
- R3: On the edge that ends a division cycle, the residue becomes (R + k) mod 2^m and `acc_carry` becomes 1 exactly when R + k ≥ 2^m (m = FRAC_W, k = `frac_k`, both unsigned).
- R4: On that same edge, `div_ratio` becomes `int_n` + `acc_carry` (the new carry), and the next division cycle lasts that many strobes. `int_n` and `frac_k` are sampled only on that edge.
- R5: With `frac_k` = 0, `acc_carry` never asserts and every division cycle is `int_n` strobes long.
- R6: Over any 2^m consecutive division cycles with a fixed `frac_k`, `acc_carry` asserts exactly `frac_k` times, so the average ratio is `int_n` + `frac_k`/2^m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| cyc_stb | input | 1 | Strobe marking one input edge to be counted |
| int_n | input | INT_W | Integer part N of the division ratio (≥ 1) |
| frac_k | input | FRAC_W | Fractional word k |
| div_out | output | 1 | One-cycle pulse at the end of each division cycle |
| acc_carry | output | 1 | Registered accumulator carry; 1 while the current cycle is N+1 |
| acc_res | output | FRAC_W | Accumulator residue |
| div_ratio | output | INT_W+1 | Division ratio of the cycle now in progress |

## Verification
The assertions check four behaviours on every cycle. Each end-of-cycle pulse must show a residue and carry equal to the previous residue plus the sampled k. The ratio loaded at each pulse must equal the sampled N plus the new carry. A low strobe must leave the state untouched. A zero fractional word must never produce a carry. Other properties show up only across whole scenarios, and the bench's scoreboard covers them: the true length of each division cycle counted in strobes, the exact carry count over 2^m cycles for several k values, and correct behaviour when the strobe is sparse and when N and k change between cycles.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  // Length of the single start-up division cycle after reset
  localparam int unsigned START_RATIO = 1;

  // What the down-counter does on a given clock edge
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_COUNT = 2'd1,
    STEP_WRAP  = 2'd2
  } step_e;

endpackage

// File: rtl/fracn_accum.sv
module fracn_accum #(
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FRAC_W-1:0] k_in,
  output logic              carry_nxt,
  output logic              carry_q,
  output logic [FRAC_W-1:0] res_q
);

  localparam int unsigned SUM_W = FRAC_W + 1;

  logic [SUM_W-1:0]  sum;
  logic [FRAC_W-1:0] res_d;
  logic              carry_d;

  always_comb begin
    sum       = {1'b0, res_q} + {1'b0, k_in};
    carry_nxt = sum[FRAC_W];
    res_d     = res_q;
    carry_d   = carry_q;
    if (step) begin
      res_d   = sum[FRAC_W-1:0];
      carry_d = sum[FRAC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      res_q   <= res_d;
      carry_q <= carry_d;
    end
  end

endmodule

// File: rtl/fracn_downcnt.sv
module fracn_downcnt
  import fracn_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [CNT_W-1:0] load_val,
  output logic             term
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  step_e            step;

  always_comb begin
    if (!stb)             step = STEP_HOLD;
    else if (cnt_q == ONE) step = STEP_WRAP;
    else                  step = STEP_COUNT;
  end

  assign term = (step == STEP_WRAP);

  always_comb begin
    case (step)
      STEP_WRAP:  cnt_d = load_val;
      STEP_COUNT: cnt_d = cnt_q - ONE;
      default:    cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(START_RATIO);
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl
  import fracn_pkg::*;
#(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic [INT_W-1:0]  int_n,
  input  logic [FRAC_W-1:0] frac_k,
  output logic              div_out,
  output logic              acc_carry,
  output logic [FRAC_W-1:0] acc_res,
  output logic [INT_W:0]    div_ratio
);

  localparam int unsigned RAT_W = INT_W + 1;

  logic             cyc_end;
  logic             carry_nxt;
  logic [RAT_W-1:0] ratio_nxt;
  logic [RAT_W-1:0] ratio_d;
  logic [RAT_W-1:0] ratio_q;
  logic             pulse_q;

  fracn_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (cyc_end),
    .k_in      (frac_k),
    .carry_nxt (carry_nxt),
    .carry_q   (acc_carry),
    .res_q     (acc_res)
  );

  always_comb begin
    ratio_nxt = {1'b0, int_n} + RAT_W'(carry_nxt);
    ratio_d   = cyc_end ? ratio_nxt : ratio_q;
  end

  fracn_downcnt #(.CNT_W(RAT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (cyc_stb),
    .load_val (ratio_nxt),
    .term     (cyc_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RAT_W'(START_RATIO);
      pulse_q <= 1'b0;
    end else begin
      ratio_q <= ratio_d;
      pulse_q <= cyc_end;
    end
  end

  assign div_out   = pulse_q;
  assign div_ratio = ratio_q;

endmodule

// File: rtl/fracn_divctl_chk.sv
module fracn_divctl_chk #(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_stb,
  input logic [INT_W-1:0]  int_n,
  input logic [FRAC_W-1:0] frac_k,
  input logic              div_out,
  input logic              acc_carry,
  input logic [FRAC_W-1:0] acc_res,
  input logic [INT_W:0]    div_ratio
);

  // R3
  res_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> ({acc_carry, acc_res} ==
                 ({1'b0, $past(acc_res)} + {1'b0, $past(frac_k)})));

  // R4
  ratio_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> (div_ratio == ({1'b0, $past(int_n)} + {{INT_W{1'b0}}, acc_carry})));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_stb) |-> ($stable(acc_res) && $stable(acc_carry) &&
                         $stable(div_ratio) && !div_out));

  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> $past(cyc_stb));

  // R5
  zero_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_out && ($past(frac_k) == '0)) |-> !acc_carry);

endmodule

bind fracn_divctl fracn_divctl_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_stb   (cyc_stb),
  .int_n     (int_n),
  .frac_k    (frac_k),
  .div_out   (div_out),
  .acc_carry (acc_carry),
  .acc_res   (acc_res),
  .div_ratio (div_ratio)
);

// File: tb/test_fracn_divctl.sv
`timescale 1ns/1ps
module test_fracn_divctl;

  localparam int INT_W  = 8;
  localparam int FRAC_W = 4;
  localparam int MODV   = 1 << FRAC_W;

  logic              clk;
  logic              rst_n;
  logic              cyc_stb;
  logic [INT_W-1:0]  int_n;
  logic [FRAC_W-1:0] frac_k;
  logic              div_out;
  logic              acc_carry;
  logic [FRAC_W-1:0] acc_res;
  logic [INT_W:0]    div_ratio;

  fracn_divctl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_fracn_divctl (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .int_n(int_n),
    .frac_k(frac_k), .div_out(div_out), .acc_carry(acc_carry),
    .acc_res(acc_res), .div_ratio(div_ratio)
  );

  typedef struct {
    int ratio;
    int carry;
    int res;
    int period;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   en_mode = -1;
  int   en_ph = 0;
  int   since = 0;
  int   pulses_seen = 0;
  int   carry_seen = 0;
  int   m_res = 0;
  int   m_prev = 1;
  bit   done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items on every end-of-cycle pulse and drives the strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (div_out) begin
        if (exp_q.size() == 0) begin
          check("R2", "unexpected pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R2", "cycle length in strobes", since, e.period);
          check("R3", "residue", int'(acc_res), e.res);
          check("R3", "carry", int'(acc_carry), e.carry);
          check("R4", "ratio", int'(div_ratio), e.ratio);
        end
        pulses_seen++;
        if (acc_carry) carry_seen++;
        since = 0;
      end
      case (en_mode)
        0:       cyc_stb = 1'b1;
        1:       begin cyc_stb = (en_ph % 3 == 0); en_ph++; end
        default: cyc_stb = 1'b0;
      endcase
      if (cyc_stb) since++;
    end else begin
      cyc_stb = 1'b0;
    end
  end

  // Driver: sets N and k, pushes the expected pulses, waits for them
  task automatic seg(input int n, input int kk, input int cnt, input int mode);
    int c0;
    int target;
    int s;
    int c;
    int_n  = INT_W'(n);
    frac_k = FRAC_W'(kk);
    for (int i = 0; i < cnt; i++) begin
      exp_t e;
      s = m_res + kk;
      c = (s >= MODV) ? 1 : 0;
      m_res = s % MODV;
      e.ratio = n + c;
      e.carry = c;
      e.res = m_res;
      e.period = m_prev;
      m_prev = n + c;
      exp_q.push_back(e);
    end
    c0 = carry_seen;
    target = pulses_seen + cnt;
    en_mode = mode;
    wait (pulses_seen >= target);
    #1;
    if (cnt == MODV) begin
      if (kk == 0) check("R5", "carries with zero k", carry_seen - c0, 0);
      else         check("R6", "carries per 2^m cycles", carry_seen - c0, kk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cyc_stb = 1'b0;
    int_n = INT_W'(3);
    frac_k = FRAC_W'(5);
    repeat (3) @(negedge clk);
    // R1: state while held in reset
    check("R1", "residue in reset", int'(acc_res), 0);
    check("R1", "ratio in reset", int'(div_ratio), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: state after release, before any strobe
    check("R1", "residue after release", int'(acc_res), 0);
    check("R1", "carry after release", int'(acc_carry), 0);
    check("R1", "pulse after release", int'(div_out), 0);
    check("R1", "ratio after release", int'(div_ratio), 1);
    seg(3, 5, MODV, 0);
    seg(2, 0, MODV, 0);
    seg(4, 15, MODV, 1);
    seg(1, 8, MODV, 0);
    seg(6, 1, MODV, 1);
    seg(5, 11, 5, 0);
    seg(2, 3, MODV, 1);
    en_mode = -1;
    repeat (4) @(negedge clk);
    #1;
    check("R2", "leftover expected pulses", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule